// File: doc/BRIEF.md
# Token-Gated Target Clock Wrapper

This block wraps one piece of target logic so that it advances at its own pace, set by token handshakes rather than by every host clock edge. The wrapper has a number of peers: the top-level IO and every sibling instance. For each peer it offers one incoming token channel and one outgoing token channel. Each channel has a 1-bit valid signal that flows forward and a 1-bit ready signal that flows back.

The handshakes combine into a single step signal. Step is high only when every incoming channel shows a token and every outgoing consumer is ready. In that same cycle the target clock pulses once, and every outgoing channel presents a token. When step is low, the target clock stays low and the target keeps its state. The target's ordinary data and reset ports pass through unchanged.

The clock gate latches step while the host clock is low. Because of this, the gated clock cannot glitch when the handshakes change in the low phase. The wrapped target here is an accumulator with a step counter. It stands in for any synchronous logic whose only clock is the gated one.

Top module: `token_gated_wrapper`

## Requirements
- R1: Every incoming channel's ready output (`peer_in_ready`) is 1 in every cycle, including during reset.
- R2: All bits of `peer_out_valid` are equal. They are 1 exactly when every bit of `peer_in_valid` and every bit of `peer_out_ready` is 1, combinationally in the same cycle.
- R3: `tgt_steps` increases by exactly 1 (wrapping modulo 2^16) on each host clock edge at which the step condition of R2 holds and `tgt_rst_n` is 1.
- R4: On a host clock edge where the step condition is false, `tgt_acc` and `tgt_steps` keep their values. This holds for any number of consecutive such edges.
- R5: On a stepping edge with `tgt_rst_n` at 1, `tgt_acc` becomes its previous value plus `tgt_din`, modulo 2^8. The `tgt_din` value used is the one present at that edge.
- R6: `tgt_rst_n` is a synchronous active-low reset of the target. It clears `tgt_acc` and `tgt_steps` to 0 only on a stepping edge. While step is low, a low `tgt_rst_n` changes nothing.
- R7: Pulling any single one of the 2×NUM_PEERS handshake inputs low blocks the step, whichever lane it is. Here `peer_in_valid[i]` and `peer_out_ready[i]` are bit i for peer i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Free-running host clock |
| peer_in_valid | input | NUM_PEERS | Token present on each incoming channel |
| peer_in_ready | output | NUM_PEERS | Incoming channel ready, held at 1 |
| peer_out_valid | output | NUM_PEERS | Token offered on each outgoing channel (the step signal) |
| peer_out_ready | input | NUM_PEERS | Consumer of each outgoing channel can accept |
| tgt_rst_n | input | 1 | Target synchronous active-low reset, passed through |
| tgt_din | input | DATA_W | Target data input, passed through |
| tgt_acc | output | DATA_W | Target accumulator, passed through |
| tgt_steps | output | CNT_W | Target step counter, passed through |

## Verification
A latch that leaks the step signal into the high phase would give an extra or a missing target edge. The step counter would then drift from the bench's count of stepping edges, and the drift shows in the first cycle after the bad edge. A reduction that drops one lane would let the target step while that lane is low. It would also raise `peer_out_valid` in that same cycle, so the fault is visible combinationally. A stall that does not fully freeze the target shows as a change in `tgt_acc` or `tgt_steps` one edge after a non-stepping cycle.

// File: rtl/tgw_pkg.sv
// Package tgw_pkg
// Shared widths and types for the token-gated wrapper.
// Assumes: every module in this project imports it.
package tgw_pkg;
    localparam int unsigned DEF_PEERS  = 3;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_CNT_W  = 16;

    // Step state of the wrapper, used for readability in the top.
    typedef enum logic {
        STALL = 1'b0,
        STEP  = 1'b1
    } step_e;
endpackage

// File: rtl/tgw_fire_reduce.sv
// Module tgw_fire_reduce
// ANDs every incoming valid and every outgoing ready into one step flag.
// Assumes: NUM_PEERS >= 2. The AND chain is built by generate, so any
// legal count elaborates to the same function.
module tgw_fire_reduce #(
    parameter int unsigned NUM_PEERS = tgw_pkg::DEF_PEERS
) (
    input  logic [NUM_PEERS-1:0] in_valid,
    input  logic [NUM_PEERS-1:0] out_ready,
    output logic                 step
);
    localparam int unsigned NTERMS = 2 * NUM_PEERS;

    logic [NTERMS-1:0] terms;
    logic [NTERMS:0]   chain;

    if (NUM_PEERS < 2) begin : g_bad_count
        initial $error("tgw_fire_reduce needs at least two peers");
    end

    // Gather all handshake lanes into one vector.
    assign terms    = {out_ready, in_valid};
    assign chain[0] = 1'b1;

    for (genvar g = 0; g < NTERMS; g++) begin : g_and
        // One AND stage per lane.
        assign chain[g+1] = chain[g] & terms[g];
    end

    assign step = chain[NTERMS];

    // R7: a single low incoming valid must block the step.
    always_comb begin
        if (step) begin
            assert_lane_blocks_R7 : assert (in_valid == '1 && out_ready == '1);
        end
    end
endmodule

// File: rtl/tgw_clock_gate.sv
// Module tgw_clock_gate
// Glitch-free clock gate: the enable is captured by a latch that is
// transparent while the clock is low, then ANDed with the clock.
// Assumes: the enable settles before the rising edge of clk_i.
module tgw_clock_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    // Follow the enable only during the low phase of the clock.
    always_latch begin
        if (!clk_i) begin
            en_lat = en_i;
        end
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/tgw_target.sv
// Module tgw_target
// Example wrapped target: an accumulator plus a count of its own clock
// edges. It runs only on the gated clock.
// Assumes: rst_n is synchronous to clk and active low.
module tgw_target #(
    parameter int unsigned DATA_W = tgw_pkg::DEF_DATA_W,
    parameter int unsigned CNT_W  = tgw_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] acc,
    output logic [CNT_W-1:0]  steps
);
    // Add the input into the accumulator on every target edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc + din;
        end
    end

    // Count target edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps <= '0;
        end else begin
            steps <= steps + 1'b1;
        end
    end
endmodule

// File: rtl/token_gated_wrapper.sv
// Module token_gated_wrapper
// Wraps one target instance behind token channels, one in and one out
// per peer. The target clock pulses only when every incoming token is
// present and every outgoing consumer is ready. The target's data and
// reset ports pass straight through.
// Assumes: NUM_PEERS >= 2, and handshake inputs change away from the
// rising edge of host_clk.
module token_gated_wrapper #(
    parameter int unsigned NUM_PEERS = tgw_pkg::DEF_PEERS,
    parameter int unsigned DATA_W    = tgw_pkg::DEF_DATA_W,
    parameter int unsigned CNT_W     = tgw_pkg::DEF_CNT_W
) (
    input  logic                 host_clk,
    input  logic [NUM_PEERS-1:0] peer_in_valid,
    output logic [NUM_PEERS-1:0] peer_in_ready,
    output logic [NUM_PEERS-1:0] peer_out_valid,
    input  logic [NUM_PEERS-1:0] peer_out_ready,
    input  logic                 tgt_rst_n,
    input  logic [DATA_W-1:0]    tgt_din,
    output logic [DATA_W-1:0]    tgt_acc,
    output logic [CNT_W-1:0]     tgt_steps
);
    import tgw_pkg::*;

    logic  step_raw;
    step_e step_st;
    logic  tgt_clk;

    // Reduce all handshakes into the step flag.
    tgw_fire_reduce #(
        .NUM_PEERS (NUM_PEERS)
    ) i_reduce (
        .in_valid  (peer_in_valid),
        .out_ready (peer_out_ready),
        .step      (step_raw)
    );

    assign step_st = step_raw ? STEP : STALL;

    // Incoming channels always accept; outgoing tokens mark the step.
    assign peer_in_ready  = '1;
    assign peer_out_valid = {NUM_PEERS{step_st == STEP}};

    // Derive the target clock from the host clock and the step flag.
    tgw_clock_gate i_gate (
        .clk_i  (host_clk),
        .en_i   (step_raw),
        .gclk_o (tgt_clk)
    );

    // Wrapped target, ordinary ports passed through.
    tgw_target #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_target (
        .clk   (tgt_clk),
        .rst_n (tgt_rst_n),
        .din   (tgt_din),
        .acc   (tgt_acc),
        .steps (tgt_steps)
    );

    // R2: outgoing valids agree with each other.
    assert_out_valid_uniform_R2 : assert property (@(posedge host_clk)
        disable iff (!tgt_rst_n)
        ($countones(peer_out_valid) == 0) || ($countones(peer_out_valid) == NUM_PEERS));

    // R3: one target edge per stepping host edge.
    assert_step_counts_R3 : assert property (@(posedge host_clk)
        disable iff (!tgt_rst_n)
        (peer_out_valid[0] && tgt_rst_n) |=> (tgt_steps == $past(tgt_steps) + 1'b1));

    // R4: no step, no change.
    assert_stall_holds_steps_R4 : assert property (@(posedge host_clk)
        disable iff (!tgt_rst_n)
        !peer_out_valid[0] |=> $stable(tgt_steps));

    assert_stall_holds_acc_R4 : assert property (@(posedge host_clk)
        disable iff (!tgt_rst_n)
        !peer_out_valid[0] |=> $stable(tgt_acc));

    // R5: accumulate the input present at the stepping edge.
    assert_acc_adds_R5 : assert property (@(posedge host_clk)
        disable iff (!tgt_rst_n)
        (peer_out_valid[0] && tgt_rst_n) |=> (tgt_acc == $past(tgt_acc) + $past(tgt_din)));
endmodule

// File: tb/test_token_gated_wrapper.sv
`timescale 1ns/1ps
module test_token_gated_wrapper;
    localparam int unsigned NP = 3;
    localparam int unsigned DW = 8;
    localparam int unsigned CW = 16;
    localparam int unsigned NV = 12;

    // Vector: {in_valid[2:0], out_ready[2:0], din[7:0]}
    localparam logic [13:0] VEC [0:NV-1] = '{
        {3'b111, 3'b111, 8'h05},
        {3'b111, 3'b111, 8'h10},
        {3'b011, 3'b111, 8'h40},
        {3'b111, 3'b110, 8'h22},
        {3'b111, 3'b111, 8'hF0},
        {3'b111, 3'b111, 8'h20},
        {3'b000, 3'b000, 8'h33},
        {3'b101, 3'b111, 8'h01},
        {3'b111, 3'b011, 8'h02},
        {3'b111, 3'b111, 8'hFF},
        {3'b110, 3'b101, 8'h77},
        {3'b111, 3'b111, 8'h03}
    };

    logic          host_clk = 1'b0;
    logic [NP-1:0] peer_in_valid = '0;
    logic [NP-1:0] peer_in_ready;
    logic [NP-1:0] peer_out_valid;
    logic [NP-1:0] peer_out_ready = '0;
    logic          tgt_rst_n = 1'b0;
    logic [DW-1:0] tgt_din = '0;
    logic [DW-1:0] tgt_acc;
    logic [CW-1:0] tgt_steps;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] m_acc = '0;
    logic [CW-1:0] m_steps = '0;

    token_gated_wrapper #(.NUM_PEERS(NP), .DATA_W(DW), .CNT_W(CW)) i_token_gated_wrapper (
        .host_clk       (host_clk),
        .peer_in_valid  (peer_in_valid),
        .peer_in_ready  (peer_in_ready),
        .peer_out_valid (peer_out_valid),
        .peer_out_ready (peer_out_ready),
        .tgt_rst_n      (tgt_rst_n),
        .tgt_din        (tgt_din),
        .tgt_acc        (tgt_acc),
        .tgt_steps      (tgt_steps)
    );

    always #10 host_clk = ~host_clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // One host cycle: drive at negedge, check handshakes, then state.
    task automatic step(input logic [NP-1:0] v, input logic [NP-1:0] r,
                        input logic [DW-1:0] d, input logic rs, input string req);
        logic fire;
        @(negedge host_clk);
        peer_in_valid  = v;
        peer_out_ready = r;
        tgt_din        = d;
        tgt_rst_n      = rs;
        fire = (&v) & (&r);
        #1;
        check("R1 in_ready", 32'(peer_in_ready), 32'({NP{1'b1}}));
        check({req, " R2 out_valid"}, 32'(peer_out_valid), 32'({NP{fire}}));
        if (fire) begin
            if (!rs) begin
                m_acc = '0;
                m_steps = '0;
            end else begin
                m_acc = m_acc + d;
                m_steps = m_steps + 1'b1;
            end
        end
        @(posedge host_clk);
        #2;
        check({req, " acc"}, 32'(tgt_acc), 32'(m_acc));
        check({req, " steps"}, 32'(tgt_steps), 32'(m_steps));
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R6: reset applied with the step condition clears the target.
        step('1, '1, 8'h00, 1'b0, "R6 reset");
        step('1, '1, 8'h00, 1'b0, "R6 reset");
        check("R6 reset acc", 32'(tgt_acc), 32'h0);
        check("R6 reset steps", 32'(tgt_steps), 32'h0);

        // R3 R5 R7: table of handshake patterns.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13:11], VEC[i][10:8], VEC[i][7:0], 1'b1, "R3 R5 table");
        end

        // R4: long stall, state frozen.
        for (int i = 0; i < 40; i++) begin
            step(3'b110, '1, 8'(i + 1), 1'b1, "R4 stall");
        end

        // R7: each lane on its own blocks the step.
        for (int i = 0; i < NP; i++) begin
            step(~(NP'(1) << i), '1, 8'h11, 1'b1, "R7 valid lane");
            step('1, ~(NP'(1) << i), 8'h11, 1'b1, "R7 ready lane");
        end

        // R6: reset without a step has no effect.
        step(3'b111, 3'b111, 8'h09, 1'b1, "R5 preload");
        for (int i = 0; i < 4; i++) begin
            step(3'b111, 3'b101, 8'h00, 1'b0, "R6 reset no step");
        end
        // R6: reset with a step clears.
        step('1, '1, 8'h00, 1'b0, "R6 reset step");
        check("R6 cleared acc", 32'(tgt_acc), 32'h0);

        // R3: steady run of steps after reset.
        for (int i = 0; i < 20; i++) begin
            step('1, '1, 8'(3 * i), 1'b1, "R3 run");
        end
        check("R3 final steps", 32'(tgt_steps), 32'd20);

        finish_run();
    end
endmodule